// File: doc/BRIEF.md
# Reconfigurable Broadcast Scan Decompressor

This block lets a small number of external scan-in pins load a much larger number of short internal scan chains in parallel. Every chain has its own selector that picks one of the pins as its source. Because one pin can feed many chains at the same time, a bit the tester sends as required data for one chain also serves as filler on every other chain that picks the same pin.

Which pin feeds which chain is not fixed. A two-bit configuration code and a bypass flag arrive on dedicated inputs together with the scan data. They are sampled on the same clock edge as that data, so the routing can change on every shift cycle. Four fixed routings are offered. The bypass flag overrides them: it ties the first P chains one-to-one to the pins and drives the remaining chains to zero. Only bit patterns that one of these routings can produce are possible; an arbitrary combination of values across the chains is not guaranteed. The chain inputs are registered. While shift enable is low they hold their value, and the incoming configuration is ignored.

Top module: `bcast_scan_decomp`

## Requirements
- R1: While rst_n is low, every bit of chain_out is 0.
- R2: On a rising clock edge with shift_en low, chain_out keeps its value. cfg_sel, byp_en and scan_in presented in that cycle have no effect on it.
- R3: With shift_en high, byp_en low and cfg_sel = 2'b00 at a rising edge, every chain_out bit takes the value of scan_in[0] from that edge.
- R4: With shift_en high, byp_en low and cfg_sel = 2'b01, chain_out[i] takes scan_in[i mod P].
- R5: With shift_en high, byp_en low and cfg_sel = 2'b10, chain_out[i] takes scan_in[(i/2) mod P], using integer division.
- R6: With shift_en high, byp_en low and cfg_sel = 2'b11, chain_out[i] takes scan_in[P-1-(i mod P)].
- R7: With shift_en high and byp_en high, chain_out[i] takes scan_in[i] for i < P and 0 for i >= P, whatever the value of cfg_sel.
- R8: The configuration is sampled on the same edge as the data it routes. A different configuration on each consecutive shift cycle takes effect on each of those cycles, and chain_out shows the result one clock after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Advance the chain inputs on this edge |
| scan_in | input | P | External scan-in pins |
| cfg_sel | input | 2 | Routing code for this shift cycle |
| byp_en | input | 1 | One-to-one pin routing, remaining chains at 0 |
| chain_out | output | N | Registered serial inputs of the internal chains |

## Verification
The hold function and a configuration change can fall in the same cycle. The bench provokes this by presenting a new cfg_sel, an asserted byp_en and fresh scan data while shift_en is low. It judges the result by requiring chain_out to stay unchanged on that edge and then to follow the new routing on the next edge that has shift_en high. Random cycles mix shift_en, the four codes and bypass, so holds that straddle configuration switches recur throughout the run.

// File: rtl/bcast_scan_decomp.sv
module bcast_scan_decomp #(
  parameter int P = 4,
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic [P-1:0] scan_in,
  input  logic [1:0]   cfg_sel,
  input  logic         byp_en,
  output logic [N-1:0] chain_out
);

  logic [N-1:0] fan;

  for (genvar i = 0; i < N; i++) begin : g_ch
    localparam int SMOD = i % P;
    localparam int SHALF = (i / 2) % P;
    localparam int SREV = P - 1 - (i % P);
    logic routed;

    always_comb begin
      case (cfg_sel)
        2'd0:    routed = scan_in[0];
        2'd1:    routed = scan_in[SMOD];
        2'd2:    routed = scan_in[SHALF];
        default: routed = scan_in[SREV];
      endcase
    end

    if (i < P) begin : g_direct
      assign fan[i] = byp_en ? scan_in[i] : routed;
      a_r7_bypass_pin: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en && byp_en |=> chain_out[i] == $past(scan_in[i]));
    end else begin : g_zero
      assign fan[i] = byp_en ? 1'b0 : routed;
      a_r7_bypass_zero: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en && byp_en |=> !chain_out[i]);
    end

    a_r4_modulo: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en && !byp_en && cfg_sel == 2'd1 |=> chain_out[i] == $past(scan_in[SMOD]));
    a_r5_paired: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en && !byp_en && cfg_sel == 2'd2 |=> chain_out[i] == $past(scan_in[SHALF]));
    a_r6_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en && !byp_en && cfg_sel == 2'd3 |=> chain_out[i] == $past(scan_in[SREV]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain_out <= '0;
    else if (shift_en) chain_out <= fan;
  end

  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> chain_out == '0);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(chain_out));
  a_r3_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en && !byp_en && cfg_sel == 2'd0 |=> chain_out == {N{$past(scan_in[0])}});

endmodule

// File: tb/bcast_scan_decomp_tb.sv
`timescale 1ns/1ps
module bcast_scan_decomp_tb;
  localparam int P = 4;
  localparam int N = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic shift_en = 0;
  logic [P-1:0] scan_in = '0;
  logic [1:0] cfg_sel = 2'd0;
  logic byp_en = 0;
  logic [N-1:0] chain_out;
  logic [N-1:0] exp_q;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bcast_scan_decomp #(.P(P), .N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .scan_in(scan_in),
    .cfg_sel(cfg_sel), .byp_en(byp_en), .chain_out(chain_out));

  function automatic logic [N-1:0] ref_route(logic [P-1:0] s, logic [1:0] m, logic b);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (b)              r[i] = (i < P) ? s[i] : 1'b0;
      else if (m == 2'd0) r[i] = s[0];
      else if (m == 2'd1) r[i] = s[i % P];
      else if (m == 2'd2) r[i] = s[(i / 2) % P];
      else                r[i] = s[P - 1 - (i % P)];
    end
    return r;
  endfunction

  function automatic string tag_of(logic sh, logic [1:0] m, logic b);
    if (!sh) return "R2";
    if (b) return "R7";
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag);
    n_run++;
    if (chain_out !== exp_q) begin
      n_fail++;
      $display("FAIL %s: chain_out=%h expected=%h", tag, chain_out, exp_q);
    end
  endtask

  task automatic step(logic sh, logic [P-1:0] s, logic [1:0] m, logic b, string tag);
    shift_en = sh; scan_in = s; cfg_sel = m; byp_en = b;
    if (sh) exp_q = ref_route(s, m, b);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    exp_q = '0;
    shift_en = 1; scan_in = '1; cfg_sel = 2'd1;
    repeat (3) @(negedge clk);
    check("R1");
    shift_en = 0;
    rst_n = 1;
    @(negedge clk);
    check("R1");

    step(1, 4'b0001, 2'd0, 0, "R3");
    step(1, 4'b1110, 2'd0, 0, "R3");
    step(1, 4'b0110, 2'd1, 0, "R4");
    step(1, 4'b1011, 2'd1, 0, "R8 R4");
    step(1, 4'b1011, 2'd2, 0, "R8 R5");
    step(1, 4'b1011, 2'd3, 0, "R8 R6");
    step(1, 4'b1011, 2'd0, 1, "R8 R7");
    step(1, 4'b0101, 2'd3, 1, "R7");
    step(0, 4'b1111, 2'd2, 1, "R2");
    step(0, 4'b0000, 2'd0, 0, "R2");
    step(1, 4'b1001, 2'd2, 0, "R5");
    step(0, 4'b0110, 2'd3, 1, "R2");
    step(1, 4'b0110, 2'd3, 1, "R7");
    step(1, 4'b0001, 2'd3, 0, "R6");

    for (int k = 0; k < 300; k++) begin
      logic sh;
      logic [P-1:0] s;
      logic [1:0] m;
      logic b;
      sh = ($urandom % 5) != 0;
      s = P'($urandom);
      m = 2'($urandom);
      b = ($urandom % 4) == 0;
      step(sh, s, m, b, tag_of(sh, m, b));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule